// File: doc/BRIEF.md
# Register-Controlled SPI Frame Engine

This block is an SPI master that moves a whole frame of words without help from software once the frame has begun. Software places left-aligned words in a 64-entry transmit queue. It programs a word length of 8 to 32 bits and a word count, chooses clock polarity, sampling edge and bit order, and then sets a frame-start bit. The engine shifts the programmed number of words out on the data output. It captures the same number of words from the data input into a 64-entry receive queue, flags the end of the frame in a status register and raises an interrupt when that flag is enabled.

A sequencer with five states does the shifting. IDLE holds the clock at its idle level. IDLE→LOAD happens when frame-start and clock-enable are both applied. LOAD fetches the next transmit word and clears the receive word, and LOAD→LEAD follows on the next cycle. LEAD is the first half of a bit slot, and LEAD→TRAIL is the sampling edge. TRAIL is the second half of the slot. TRAIL→LEAD moves to the next bit, TRAIL→LOAD moves to the next word, and TRAIL→DONE ends the frame. DONE holds until frame-start is cleared. Clearing frame-start takes every state back to IDLE (ANY→IDLE). While clock-enable is low, every state holds.

Top module: `spi_frame_engine`

Register addresses (byte offsets): FORMAT 0x00, FRAME 0x04, CTRL 0x08, STAT 0x0C, IEN 0x10, TXD 0x14 (a write pushes a word), RXD 0x18 (a read with rd_en_i pops a word).

## Requirements
- R1: After reset, CTRL, STAT and IEN read zero, irq_o is low, sck_o is low and mosi_oe_o is high.
- R2: The CTRL bits for clock enable (15), frame start (14), transmit enable (9) and receive enable (8) read back the state applied inside the engine. A written value shows up in the readback one clock after the write takes effect, not at once.
- R3: A frame shifts (FRAME[23:16]+1) words of (FRAME[28:24]+1) bits each. Each transmitted word comes from the top bits of its 32-bit queue entry, and by default the first bit sent is bit 31.
- R4: Each received word is stored left-aligned, with its bits at the same positions the transmit side uses and all lower bits zero. A read of RXD with rd_en_i returns the oldest word and removes it.
- R5: When FORMAT[24] is 1, bits go out and come in least significant first: the first bit is bit 32−length, and the last is bit 31.
- R6: sck_o rests at CTRL[30] outside bit slots. Data is sampled on the rising edge of sck_o when CTRL[27] is 1 and on the falling edge when it is 0. mosi_o changes only at the start of a slot, so it is stable at the sampling edge.
- R7: When FRAME[0] is 1, mosi_o stays 0 for the whole frame and the transmit queue is not popped.
- R8: At the end of a frame, STAT[23] is set if the transmitter is enabled and STAT[7] is set if the receiver is enabled. Writing 1 to a STAT bit clears only that bit.
- R9: irq_o is the OR of STAT AND IEN over bits 23 and 7. It stays high until the status is cleared or the enable is removed.
- R10: When CTRL[23:22] is 2'b10, mosi_oe_o is low outside bit slots and high during them. For any other value mosi_oe_o stays high.
- R11: Clearing frame-start in the middle of a frame returns sck_o to its idle level and sets no status. The next frame starts again at word 0, bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; one bit slot is two cycles |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write byte address |
| wr_data_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Read strobe; pops the receive queue when the address is RXD |
| rd_addr_i | input | ADDR_W | Register read byte address |
| rd_data_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | End-of-frame interrupt |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Output enable for mosi_o |
| miso_i | input | 1 | Serial data in |

## Verification
A wrong bit or word counter shows at the ports within one frame. It changes the number of sampling edges the slave model counts, and it makes irq_o arrive early, late or not at all. A wrong bit index or bit-order decode corrupts the very first word. It shows both in the bits the slave captures and in the word read back from RXD. A sequencer that does not leave its state on abort keeps sck_o away from its idle level or leaves a status flag set within a few cycles. The next frame then also returns misaligned words.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
    localparam int WORD_W   = 32;

    // register byte offsets
    localparam int A_FORMAT = 'h00;
    localparam int A_FRAME  = 'h04;
    localparam int A_CTRL   = 'h08;
    localparam int A_STAT   = 'h0C;
    localparam int A_IEN    = 'h10;
    localparam int A_TXD    = 'h14;
    localparam int A_RXD    = 'h18;

    // bit positions
    localparam int B_LSB    = 24;
    localparam int B_NOTX   = 0;
    localparam int B_POL    = 30;
    localparam int B_RISE   = 27;
    localparam int B_CLKEN  = 15;
    localparam int B_START  = 14;
    localparam int B_TXEN   = 9;
    localparam int B_RXEN   = 8;
    localparam int B_TEND   = 23;
    localparam int B_REND   = 7;

    localparam logic [1:0] HIZ_SLOT = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LEAD,
        ST_TRAIL,
        ST_DONE
    } fe_state_t;
endpackage

// File: rtl/spi_fe_fifo.sv
module spi_fe_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] data_o,
    output logic             empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [PTR_W:0]   cnt_q;
    logic             do_push, do_pop;

    assign empty_o = (cnt_q == '0);
    assign do_push = push_i && (cnt_q != (PTR_W+1)'(DEPTH));
    assign do_pop  = pop_i && !empty_o;
    assign data_o  = mem_q[rp_q];

    always_ff @(posedge clk_i) begin
        if (do_push) mem_q[wp_q] <= data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= (PTR_W+1)'(DEPTH));
endmodule

// File: rtl/spi_fe_shifter.sv
module spi_fe_shifter
    import spi_fe_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              clk_en_i,
    input  logic              tx_en_i,
    input  logic              rx_en_i,
    input  logic              no_tx_i,
    input  logic              lsb_i,
    input  logic              pol_i,
    input  logic              rise_i,
    input  logic [1:0]        hiz_i,
    input  logic [4:0]        len_m1_i,
    input  logic [7:0]        cnt_m1_i,
    input  logic [WORD_W-1:0] tx_data_i,
    input  logic              tx_empty_i,
    output logic              tx_pop_o,
    output logic              rx_push_o,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              done_o,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              mosi_oe_o,
    input  logic              miso_i
);
    fe_state_t         st_q, st_d;
    logic [4:0]        bit_q;
    logic [7:0]        word_q;
    logic [WORD_W-1:0] txw_q, rxw_q;
    logic [4:0]        idx;
    logic              last_bit, last_word, take, step, slot;

    assign last_bit  = (bit_q == len_m1_i);
    assign last_word = (word_q == cnt_m1_i);
    assign idx       = lsb_i ? (5'd31 - len_m1_i + bit_q) : (5'd31 - bit_q);
    assign take      = tx_en_i && !no_tx_i && !tx_empty_i;
    assign step      = run_i && clk_en_i;

    assign tx_pop_o  = step && (st_q == ST_LOAD) && take;
    assign rx_push_o = step && (st_q == ST_TRAIL) && last_bit && rx_en_i;
    assign done_o    = step && (st_q == ST_TRAIL) && last_bit && last_word;
    assign rx_data_o = rxw_q;

    // next state
    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d = ST_IDLE;
        end else if (clk_en_i) begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_LOAD;
                ST_LOAD:  st_d = ST_LEAD;
                ST_LEAD:  st_d = ST_TRAIL;
                ST_TRAIL: st_d = !last_bit ? ST_LEAD : (last_word ? ST_DONE : ST_LOAD);
                ST_DONE:  st_d = ST_DONE;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_IDLE;
        else         st_q <= st_d;
    end

    // counters and word registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bit_q  <= '0;
            word_q <= '0;
            txw_q  <= '0;
            rxw_q  <= '0;
        end else if (!run_i) begin
            bit_q  <= '0;
            word_q <= '0;
        end else if (clk_en_i) begin
            case (st_q)
                ST_LOAD: begin
                    txw_q <= take ? tx_data_i : '0;
                    rxw_q <= '0;
                    bit_q <= '0;
                end
                ST_LEAD: begin
                    if (rx_en_i) rxw_q[idx] <= miso_i;
                end
                ST_TRAIL: begin
                    if (!last_bit)       bit_q  <= bit_q + 5'd1;
                    else if (!last_word) word_q <= word_q + 8'd1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sck_o = pol_i;
        slot  = 1'b0;
        unique case (st_q)
            ST_LEAD:  begin sck_o = !rise_i; slot = 1'b1; end
            ST_TRAIL: begin sck_o = rise_i;  slot = 1'b1; end
            default:  ;
        endcase
        mosi_o    = (slot && tx_en_i && !no_tx_i) ? txw_q[idx] : 1'b0;
        mosi_oe_o = (hiz_i != HIZ_SLOT) || slot;
    end

    assert_abort_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (st_q == ST_IDLE));
    assert_notx_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        no_tx_i |-> !tx_pop_o);
    assert_sample_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_LEAD && step) |=> $stable(mosi_o));
    assert_hiz_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hiz_i == HIZ_SLOT && (st_q == ST_IDLE || st_q == ST_DONE)) |-> !mosi_oe_o);
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_fe_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int TX_DEPTH = 64,
    parameter int RX_DEPTH = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [31:0]       wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [31:0]       rd_data_o,
    output logic              irq_o,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              mosi_oe_o,
    input  logic              miso_i
);
    localparam logic [31:0] EVT_MASK = (32'd1 << B_TEND) | (32'd1 << B_REND);

    logic        lsb_q, notx_q, pol_q, rise_q;
    logic [4:0]  len_m1_q;
    logic [7:0]  cnt_m1_q;
    logic [1:0]  hiz_q;
    logic [3:0]  en_req_q, en_app_q;   // {clock, start, tx, rx}
    logic [31:0] stat_q, ien_q, clr_m, set_m;
    logic        wr_stat, wr_ien, done, tx_pop, rx_push, rx_pop, tx_empty, rx_empty;
    logic [31:0] tx_head, rx_word, rx_head;

    assign wr_stat = wr_en_i && (wr_addr_i == ADDR_W'(A_STAT));
    assign wr_ien  = wr_en_i && (wr_addr_i == ADDR_W'(A_IEN));
    assign rx_pop  = rd_en_i && (rd_addr_i == ADDR_W'(A_RXD));

    always_comb begin
        clr_m         = wr_stat ? (wr_data_i & EVT_MASK) : '0;
        set_m         = '0;
        set_m[B_TEND] = done && en_app_q[1];
        set_m[B_REND] = done && en_app_q[0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lsb_q <= 1'b0; notx_q <= 1'b0; pol_q <= 1'b0; rise_q <= 1'b0;
            len_m1_q <= '0; cnt_m1_q <= '0; hiz_q <= '0;
            en_req_q <= '0; en_app_q <= '0;
            stat_q <= '0; ien_q <= '0;
        end else begin
            en_app_q <= en_req_q;
            stat_q   <= (stat_q & ~clr_m) | set_m;
            if (wr_ien) ien_q <= wr_data_i & EVT_MASK;
            if (wr_en_i && wr_addr_i == ADDR_W'(A_FORMAT)) lsb_q <= wr_data_i[B_LSB];
            if (wr_en_i && wr_addr_i == ADDR_W'(A_FRAME)) begin
                len_m1_q <= wr_data_i[28:24];
                cnt_m1_q <= wr_data_i[23:16];
                notx_q   <= wr_data_i[B_NOTX];
            end
            if (wr_en_i && wr_addr_i == ADDR_W'(A_CTRL)) begin
                pol_q    <= wr_data_i[B_POL];
                rise_q   <= wr_data_i[B_RISE];
                hiz_q    <= wr_data_i[23:22];
                en_req_q <= {wr_data_i[B_CLKEN], wr_data_i[B_START],
                             wr_data_i[B_TXEN], wr_data_i[B_RXEN]};
            end
        end
    end

    assign irq_o = |(stat_q & ien_q);

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            ADDR_W'(A_FORMAT): rd_data_o[B_LSB] = lsb_q;
            ADDR_W'(A_FRAME): begin
                rd_data_o[28:24]  = len_m1_q;
                rd_data_o[23:16]  = cnt_m1_q;
                rd_data_o[B_NOTX] = notx_q;
            end
            ADDR_W'(A_CTRL): begin
                rd_data_o[B_POL]   = pol_q;
                rd_data_o[B_RISE]  = rise_q;
                rd_data_o[23:22]   = hiz_q;
                rd_data_o[B_CLKEN] = en_app_q[3];
                rd_data_o[B_START] = en_app_q[2];
                rd_data_o[B_TXEN]  = en_app_q[1];
                rd_data_o[B_RXEN]  = en_app_q[0];
            end
            ADDR_W'(A_STAT): rd_data_o = stat_q;
            ADDR_W'(A_IEN):  rd_data_o = ien_q;
            ADDR_W'(A_RXD):  rd_data_o = rx_empty ? '0 : rx_head;
            default:         rd_data_o = '0;
        endcase
    end

    spi_fe_fifo #(.WIDTH(WORD_W), .DEPTH(TX_DEPTH)) tx_fifo_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .push_i(wr_en_i && wr_addr_i == ADDR_W'(A_TXD)), .data_i(wr_data_i),
        .pop_i(tx_pop), .data_o(tx_head), .empty_o(tx_empty)
    );

    spi_fe_fifo #(.WIDTH(WORD_W), .DEPTH(RX_DEPTH)) rx_fifo_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .push_i(rx_push), .data_i(rx_word),
        .pop_i(rx_pop), .data_o(rx_head), .empty_o(rx_empty)
    );

    spi_fe_shifter shifter_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .run_i(en_app_q[2]), .clk_en_i(en_app_q[3]),
        .tx_en_i(en_app_q[1]), .rx_en_i(en_app_q[0]),
        .no_tx_i(notx_q), .lsb_i(lsb_q), .pol_i(pol_q), .rise_i(rise_q),
        .hiz_i(hiz_q), .len_m1_i(len_m1_q), .cnt_m1_i(cnt_m1_q),
        .tx_data_i(tx_head), .tx_empty_i(tx_empty), .tx_pop_o(tx_pop),
        .rx_push_o(rx_push), .rx_data_o(rx_word), .done_o(done),
        .sck_o(sck_o), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o), .miso_i(miso_i)
    );

    assert_irq_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !wr_stat && !wr_ien) |=> irq_o);
    assert_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_stat && wr_data_i[B_REND] && !done) |=> !stat_q[B_REND]);
endmodule

// File: tb/spi_frame_engine_tb_top.sv
`timescale 1ns/1ps
module spi_frame_engine_tb_top;
    import spi_fe_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic        irq, sck, mosi, mosi_oe;
    logic        miso = 1'b0;

    int n_chk = 0, n_err = 0;
    bit done_flag = 0;

    logic [31:0] tx_words [8];
    logic [31:0] rx_words [8];
    logic [31:0] slv_got  [8];
    bit   slv_on = 0;
    int   slv_k = 0, slv_len = 8, slv_w = 0, slv_i = 0, slv_oe_bad = 0;
    bit   slv_lsb = 0;
    logic slv_rise = 1'b1;

    always #2.5 clk = ~clk;

    spi_frame_engine dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .irq_o(irq), .sck_o(sck), .mosi_o(mosi), .mosi_oe_o(mosi_oe), .miso_i(miso)
    );

    function automatic int bidx(int len, bit lsb, int i);
        return lsb ? (32 - len + i) : (31 - i);
    endfunction

    // slave model: capture on the sampling edge, then present the next bit
    always @(sck) begin
        if (slv_on && sck === slv_rise) begin
            slv_w = slv_k / slv_len;
            slv_i = slv_k % slv_len;
            if (slv_w < 8) slv_got[slv_w][bidx(slv_len, slv_lsb, slv_i)] = mosi;
            if (mosi_oe !== 1'b1) slv_oe_bad++;
            slv_k++;
            slv_w = slv_k / slv_len;
            slv_i = slv_k % slv_len;
            if (slv_w < 8) miso = rx_words[slv_w][bidx(slv_len, slv_lsb, slv_i)];
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int addr, logic [31:0] d);
        wr_en = 1'b1; wr_addr = 8'(addr); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int addr, bit pop, output logic [31:0] v);
        rd_addr = 8'(addr); rd_en = pop;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic run_frame(string tag, bit pol, bit rise, bit lsb, int len, int cnt,
                             bit notx, bit push, logic [1:0] hiz);
        logic [31:0] base, mask, v;
        mask = 32'hFFFF_FFFF << (32 - len);
        wr(A_STAT, 32'h0080_0080);
        if (push) for (int w = 0; w < cnt; w++) wr(A_TXD, tx_words[w]);
        wr(A_FORMAT, 32'(lsb) << 24);
        wr(A_FRAME, (32'(len - 1) << 24) | (32'(cnt - 1) << 16) | 32'(notx));
        wr(A_IEN, 32'h0080_0080);
        base = (32'(pol) << 30) | (32'(rise) << 27) | (32'(hiz) << 22) | 32'h0000_8300;
        wr(A_CTRL, base);
        chk({tag, " R6 idle sck"}, 32'(sck), 32'(pol));
        chk({tag, " R10 idle oe"}, 32'(mosi_oe), (hiz == 2'b10) ? 32'd0 : 32'd1);
        for (int w = 0; w < 8; w++) slv_got[w] = '0;
        slv_k = 0; slv_len = len; slv_lsb = lsb; slv_rise = rise; slv_oe_bad = 0;
        miso = rx_words[0][bidx(len, lsb, 0)];
        slv_on = 1;
        wr(A_CTRL, base | 32'h0000_4000);
        for (int t = 0; t < 5000 && !irq; t++) @(negedge clk);
        slv_on = 0;
        chk({tag, " R9 irq at end"}, 32'(irq), 32'd1);
        chk({tag, " R3 bit count"}, 32'(slv_k), 32'(len * cnt));
        for (int w = 0; w < cnt; w++)
            chk({tag, " R3 tx word"}, slv_got[w], notx ? 32'd0 : (tx_words[w] & mask));
        for (int w = 0; w < cnt; w++) begin
            rd(A_RXD, 1, v);
            chk({tag, " R4 rx word"}, v, rx_words[w] & mask);
        end
        rd(A_STAT, 0, v);
        chk({tag, " R8 status"}, v, 32'h0080_0080);
        chk({tag, " R10 oe in slots"}, 32'(slv_oe_bad), 32'd0);
        wr(A_CTRL, base);
        repeat (3) @(negedge clk);
        chk({tag, " R6 sck back idle"}, 32'(sck), 32'(pol));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, 0, v); chk("R1 ctrl", v, 32'd0);
        rd(A_STAT, 0, v); chk("R1 stat", v, 32'd0);
        rd(A_IEN, 0, v);  chk("R1 ien", v, 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 sck", 32'(sck), 32'd0);
        chk("R1 oe", 32'(mosi_oe), 32'd1);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(A_CTRL, 32'h0000_8300);
        rd(A_CTRL, 0, v); chk("R2 before apply", v, 32'd0);
        rd(A_CTRL, 0, v); chk("R2 after apply", v, 32'h0000_8300);
        wr(A_CTRL, 32'd0);
        rd(A_CTRL, 0, v); chk("R2 clear before apply", v, 32'h0000_8300);
        rd(A_CTRL, 0, v); chk("R2 clear applied", v, 32'd0);
    endtask

    task automatic t_status_irq();
        logic [31:0] v;
        tx_words[0] = 32'h1234_5678;
        run_frame("R8", 1'b0, 1'b1, 1'b0, 8, 1, 1'b0, 1'b1, 2'b00);
        wr(A_IEN, 32'h0000_0080);
        wr(A_STAT, 32'h0080_0000);
        rd(A_STAT, 0, v); chk("R8 w1c one bit", v, 32'h0000_0080);
        chk("R9 irq from rx end", 32'(irq), 32'd1);
        wr(A_IEN, 32'd0);
        chk("R9 irq masked", 32'(irq), 32'd0);
        wr(A_IEN, 32'h0000_0080);
        chk("R9 irq unmasked", 32'(irq), 32'd1);
        wr(A_STAT, 32'h0000_0080);
        chk("R9 irq after clear", 32'(irq), 32'd0);
        rd(A_STAT, 0, v); chk("R8 all clear", v, 32'd0);
    endtask

    task automatic t_abort();
        logic [31:0] v, keep [4];
        for (int w = 0; w < 4; w++) begin
            keep[w] = 32'hA000_0001 + 32'(w) * 32'h1111_0000;
            tx_words[w] = keep[w];
        end
        wr(A_STAT, 32'h0080_0080);
        for (int w = 0; w < 4; w++) wr(A_TXD, tx_words[w]);
        wr(A_FORMAT, 32'd0);
        wr(A_FRAME, (32'd31 << 24) | (32'd3 << 16));
        wr(A_CTRL, 32'h4000_8300);
        wr(A_CTRL, 32'h4000_C300);
        repeat (20) @(negedge clk);
        wr(A_CTRL, 32'h4000_8300);
        repeat (4) @(negedge clk);
        chk("R11 sck idle after abort", 32'(sck), 32'd1);
        rd(A_STAT, 0, v); chk("R11 no status", v, 32'd0);
        chk("R11 no irq", 32'(irq), 32'd0);
        for (int w = 0; w < 3; w++) tx_words[w] = keep[w + 1];
        run_frame("R11", 1'b1, 1'b1, 1'b0, 32, 3, 1'b0, 1'b0, 2'b00);
    endtask

    initial begin
        for (int w = 0; w < 8; w++) begin
            rx_words[w] = 32'hC3A5_1F0E ^ (32'(w) * 32'h0F1E_2D3C);
            tx_words[w] = 32'h5A3C_96E1 + 32'(w) * 32'h1357_9BDF;
            slv_got[w]  = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        t_reset();
        t_readback();
        run_frame("R3 mode0", 1'b0, 1'b1, 1'b0, 8, 3, 1'b0, 1'b1, 2'b00);
        run_frame("R5 lsb", 1'b0, 1'b0, 1'b1, 12, 2, 1'b0, 1'b1, 2'b00);
        run_frame("R6 pol1", 1'b1, 1'b0, 1'b0, 32, 2, 1'b0, 1'b1, 2'b00);
        run_frame("R5 pol1 rise", 1'b1, 1'b1, 1'b1, 20, 2, 1'b0, 1'b1, 2'b00);
        wr(A_TXD, 32'hA5A5_A5A5);
        run_frame("R7 notx", 1'b0, 1'b1, 1'b0, 8, 2, 1'b1, 1'b0, 2'b00);
        tx_words[0] = 32'hA5A5_A5A5;
        run_frame("R7 kept", 1'b0, 1'b1, 1'b0, 8, 1, 1'b0, 1'b0, 2'b00);
        tx_words[0] = 32'hF0F0_1234; tx_words[1] = 32'h0FF0_8765;
        run_frame("R10 hiz", 1'b0, 1'b1, 1'b0, 16, 2, 1'b0, 1'b1, 2'b10);
        t_status_irq();
        t_abort();

        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #750000;
        if (!done_flag) begin
            done_flag = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule